// File: doc/BRIEF.md
# Byte-Masked One-Time-Programmable Page Controller

This block is a bus-slave controller for a page store that behaves like one-time-programmable memory. The store holds a parameterised number of pages (512 by default), each 128 bits wide. Software reaches the store through a small register set: a control register, a 16-bit lane mask, a status register, a timing register and four 32-bit data words that together stage one page.

A legal write to the control register selects a page and can request a page write, a page read, or both. A page write moves the staged data words into the store. A page read moves the store into the data words. When both are requested, the write is applied first. In either direction only the byte lanes enabled in the lane mask move, and disabled bytes keep their old value at the destination. Every legal control write raises a done flag, which is cleared by writing a one to it.

The bus accepts one request per clock. Every request gets a registered response exactly one cycle later. The response carries read data and an error code that flags an illegal access width or an unmapped register. A request that is rejected changes no state.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000, the lane mask 0xFFFF, status 0x0000, timing 0x00001485, all four data words 0, and `done_o` is low.
- R2: A request whose size code is neither 1 (16-bit) nor 2 (32-bit) gets error code 1 (width) at any address, including unmapped ones, and changes no state.
- R3: Control (0x00), lane mask (0x04) and status (0x08) accept only size 1. Timing (0x0C) and the data words (0x80, 0x84, 0x88, 0x8C) accept only size 2. A legal size at the wrong register gets error code 1. A legal size at any other offset gets error code 2 (no register). In both cases no state changes.
- R4: A write to control stores the written value ANDed with 0x39FF. Its bits [8:0] select the page.
- R5: When bit 15 of a control write is set, the page {data3,data2,data1,data0} (data0 least significant) is written into the selected page.
- R6: When bit 13 of a control write is set, the selected page is copied into data0..data3, with byte 0 of the page at data0[7:0].
- R7: When bits 15 and 13 are both set, the page write completes before the page read, so the read returns the freshly merged page.
- R8: During any page transfer, bit i of the lane mask gates byte i of the 16-byte page. Bytes with a clear mask bit keep their previous value at the destination.
- R9: Every legal control write sets status bit 0, and `done_o` follows that bit. Writing to status clears each bit written as one and leaves the other bits unchanged.
- R10: The lane mask (all 16 bits), timing and the data words are fully writable and read back as written.
- R11: A page never written since reset reads as all zeros.
- R12: `rsp_valid` is high exactly in the cycle after each request. `rsp_rdata` is zero except on a legal read response, and a 16-bit register reads zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | 2 | Access size code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 2 | 0 = ok, 1 = width error, 2 = no register |
| rsp_rdata | output | 32 | Read data |
| done_o | output | 1 | Level of the done status bit |

## Verification
The hardest case to reach from the ports is a combined write-and-read on one page under a partial lane mask. In that case the data words look unchanged afterwards, so the merged page is visible only through a later read under a different mask into cleared data words. The stimulus stages distinct patterns and narrows the mask before the combined command. It then widens the mask, clears the data words and reads the page back. A cycle-level reference model compares every response and the done level on each clock. Rejected requests are followed at once by read-backs of the registers they could have disturbed.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int LANES      = 16;
    localparam int PAGE_W     = LANES * 8;
    localparam int DWORDS     = LANES / 4;

    localparam logic [15:0] CTRL_KEEP  = 16'h39FF;
    localparam int          CTRL_WR    = 15;
    localparam int          CTRL_RD    = 13;
    localparam int          DONE_BIT   = 0;
    localparam logic [15:0] LANES_RST  = 16'hFFFF;
    localparam logic [31:0] TIMING_RST = 32'h0000_1485;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RSP_OK    = 2'd0,
        RSP_WIDTH = 2'd1,
        RSP_NOREG = 2'd2
    } rsp_code_e;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_LANES,
        SEL_STAT,
        SEL_TIMING,
        SEL_DATA,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e  sel;
        logic [1:0] word;
        rsp_code_e code;
    } decode_t;

    function automatic logic is_half_reg(reg_sel_e s);
        return (s == SEL_CTRL) || (s == SEL_LANES) || (s == SEL_STAT);
    endfunction

endpackage

// File: rtl/otp_reg_decode.sv
module otp_reg_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output decode_t           dec
);
    logic legal_size;
    logic want_half;

    always_comb begin
        dec.sel  = SEL_NONE;
        dec.word = addr[3:2];
        case (addr)
            ADDR_W'(8'h00): dec.sel = SEL_CTRL;
            ADDR_W'(8'h04): dec.sel = SEL_LANES;
            ADDR_W'(8'h08): dec.sel = SEL_STAT;
            ADDR_W'(8'h0C): dec.sel = SEL_TIMING;
            ADDR_W'(8'h80),
            ADDR_W'(8'h84),
            ADDR_W'(8'h88),
            ADDR_W'(8'h8C): dec.sel = SEL_DATA;
            default:        dec.sel = SEL_NONE;
        endcase

        legal_size = (size == SZ_HALF) || (size == SZ_WORD);
        want_half  = is_half_reg(dec.sel);

        if (!legal_size)
            dec.code = RSP_WIDTH;
        else if (dec.sel == SEL_NONE)
            dec.code = RSP_NOREG;
        else if (want_half != (size == SZ_HALF))
            dec.code = RSP_WIDTH;
        else
            dec.code = RSP_OK;
    end
endmodule

// File: rtl/otp_lane_merge.sv
module otp_lane_merge #(
    parameter int N_LANES = 16
) (
    input  logic [N_LANES*8-1:0] keep_val,
    input  logic [N_LANES*8-1:0] new_val,
    input  logic [N_LANES-1:0]   lane_en,
    output logic [N_LANES*8-1:0] merged
);
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = lane_en[g] ? new_val[g*8 +: 8] : keep_val[g*8 +: 8];
    end
endmodule

// File: rtl/otp_page_store.sv
module otp_page_store #(
    parameter int PAGES  = 512,
    parameter int WIDTH  = 128,
    localparam int AW    = $clog2(PAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_page,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);
    logic [WIDTH-1:0] cells [PAGES];
    logic [PAGES-1:0] touched_q;

    always_ff @(posedge clk) begin
        if (wr_en)
            cells[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            touched_q <= '0;
        else if (wr_en)
            touched_q[wr_addr] <= 1'b1;
    end

    assign rd_page = touched_q[rd_addr] ? cells[rd_addr] : '0;
endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
    import otp_pkg::*;
#(
    parameter int PAGES  = 512,
    parameter int ADDR_W = 8,
    localparam int PAGE_AW = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              done_o
);
    decode_t           dec;
    logic [15:0]       ctrl_q;
    logic [15:0]       lanes_q;
    logic [15:0]       stat_q;
    logic [31:0]       timing_q;
    logic [PAGE_W-1:0] data_q;

    logic              acc_ok;
    logic              wr_ok;
    logic              go;
    logic              do_pw;
    logic              do_pr;
    logic [PAGE_AW-1:0] page;
    logic [PAGE_W-1:0] page_old;
    logic [PAGE_W-1:0] page_wr;
    logic [PAGE_W-1:0] page_after;
    logic [PAGE_W-1:0] data_rd;
    logic [31:0]       rd_mux;

    otp_reg_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (req_addr),
        .size (req_size),
        .dec  (dec)
    );

    assign acc_ok = req_valid && (dec.code == RSP_OK);
    assign wr_ok  = acc_ok && req_write;
    assign go     = wr_ok && (dec.sel == SEL_CTRL);
    assign do_pw  = go && req_wdata[CTRL_WR];
    assign do_pr  = go && req_wdata[CTRL_RD];
    assign page   = req_wdata[PAGE_AW-1:0];

    otp_page_store #(.PAGES(PAGES), .WIDTH(PAGE_W)) store_i (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (page),
        .rd_page (page_old),
        .wr_en   (do_pw),
        .wr_addr (page),
        .wr_data (page_wr)
    );

    // page write: staged data replaces enabled lanes of the stored page
    otp_lane_merge #(.N_LANES(LANES)) wmerge_i (
        .keep_val (page_old),
        .new_val  (data_q),
        .lane_en  (lanes_q),
        .merged   (page_wr)
    );

    assign page_after = do_pw ? page_wr : page_old;

    // page read sees the page after any write of the same command
    otp_lane_merge #(.N_LANES(LANES)) rmerge_i (
        .keep_val (data_q),
        .new_val  (page_after),
        .lane_en  (lanes_q),
        .merged   (data_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            lanes_q  <= LANES_RST;
            stat_q   <= '0;
            timing_q <= TIMING_RST;
            data_q   <= '0;
        end else if (wr_ok) begin
            case (dec.sel)
                SEL_CTRL: begin
                    ctrl_q           <= req_wdata[15:0] & CTRL_KEEP;
                    stat_q[DONE_BIT] <= 1'b1;
                    if (do_pr)
                        data_q <= data_rd;
                end
                SEL_LANES:  lanes_q  <= req_wdata[15:0];
                SEL_STAT:   stat_q   <= stat_q & ~req_wdata[15:0];
                SEL_TIMING: timing_q <= req_wdata;
                SEL_DATA:   data_q[dec.word*32 +: 32] <= req_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (dec.sel)
            SEL_CTRL:   rd_mux = {16'h0, ctrl_q};
            SEL_LANES:  rd_mux = {16'h0, lanes_q};
            SEL_STAT:   rd_mux = {16'h0, stat_q};
            SEL_TIMING: rd_mux = timing_q;
            SEL_DATA:   rd_mux = data_q[dec.word*32 +: 32];
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= RSP_OK;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid ? dec.code : RSP_OK;
            rsp_rdata <= (acc_ok && !req_write) ? rd_mux : '0;
        end
    end

    assign done_o = stat_q[DONE_BIT];
endmodule

// File: rtl/otp_page_ctrl_chk.sv
module otp_page_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic [1:0]        rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic              done_o
);
    logic ctrl_half;
    assign ctrl_half = req_valid && (req_addr == '0) && (req_size == 2'd1);

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                        // R12
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_rdata == '0));                  // R12
    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_size == 2'd0 || req_size == 2'd3))
        |=> (rsp_err == 2'd1 && $stable(done_o)));                        // R2
    AST_NOREG: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd2 && req_addr == ADDR_W'(8'h40))
        |=> (rsp_err == 2'd2 && rsp_rdata == '0));                        // R3
    AST_CTRL_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_half && req_write) |=> done_o);                             // R9
    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ctrl_half && !req_write) |=> ((rsp_rdata & ~32'h0000_39FF) == '0)); // R4
endmodule

bind otp_page_ctrl otp_page_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .done_o    (done_o)
);

// File: tb/otp_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_page_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_err;
    logic [31:0] rsp_rdata;
    logic        done_o;

    always #2 clk = ~clk;

    otp_page_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .done_o(done_o)
    );

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // reference state
    logic [15:0]  m_ctrl = 16'h0;
    logic [15:0]  m_ben  = 16'hFFFF;
    logic [15:0]  m_stat = 16'h0;
    logic [31:0]  m_tim  = 32'h1485;
    logic [31:0]  m_data [4] = '{default: 32'h0};
    logic [127:0] m_pages [int];

    logic        e_valid = 0;
    logic [1:0]  e_err   = 0;
    logic [31:0] e_rdata = 0;

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [127:0] page_get(int p);
        return m_pages.exists(p) ? m_pages[p] : 128'h0;
    endfunction

    function automatic logic [127:0] staged();
        return {m_data[3], m_data[2], m_data[1], m_data[0]};
    endfunction

    function automatic logic [127:0] mix(logic [127:0] dst, logic [127:0] src);
        logic [127:0] r = dst;
        for (int b = 0; b < 16; b++)
            if (m_ben[b]) r[b*8 +: 8] = src[b*8 +: 8];
        return r;
    endfunction

    // behavioural model: apply a request, set next-cycle expectations
    task automatic model(bit v, bit w, logic [7:0] a, logic [1:0] s, logic [31:0] d);
        int kind;   // 0 ctrl,1 ben,2 stat,3 tim,4..7 data,-1 none
        int code;
        e_valid = v; e_err = 0; e_rdata = 0;
        if (!v) return;
        kind = -1;
        if (a == 8'h00) kind = 0;
        else if (a == 8'h04) kind = 1;
        else if (a == 8'h08) kind = 2;
        else if (a == 8'h0C) kind = 3;
        else if (a >= 8'h80 && a <= 8'h8C && a[1:0] == 0) kind = 4 + (a - 8'h80) / 4;
        if (s != 1 && s != 2) code = 1;
        else if (kind < 0) code = 2;
        else if ((kind < 3) != (s == 1)) code = 1;
        else code = 0;
        e_err = code[1:0];
        if (code != 0) return;
        if (!w) begin
            case (kind)
                0: e_rdata = {16'h0, m_ctrl};
                1: e_rdata = {16'h0, m_ben};
                2: e_rdata = {16'h0, m_stat};
                3: e_rdata = m_tim;
                default: e_rdata = m_data[kind-4];
            endcase
            return;
        end
        case (kind)
            0: begin
                int p = int'(d[8:0]);
                logic [127:0] pv;
                m_ctrl = d[15:0] & 16'h39FF;
                m_stat[0] = 1'b1;
                if (d[15]) m_pages[p] = mix(page_get(p), staged());
                if (d[13]) begin
                    pv = mix(staged(), page_get(p));
                    for (int k = 0; k < 4; k++) m_data[k] = pv[k*32 +: 32];
                end
            end
            1: m_ben = d[15:0];
            2: m_stat = m_stat & ~d[15:0];
            3: m_tim = d;
            default: m_data[kind-4] = d;
        endcase
    endtask

    // one clock: compare, then drive the next request
    task automatic step(bit v, bit w, logic [7:0] a, logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        check("rsp_valid", 32'(rsp_valid), 32'(e_valid));
        check("rsp_err",   32'(rsp_err),   32'(e_err));
        check("rsp_rdata", rsp_rdata, e_rdata);
        check("done_o",    32'(done_o),    32'(m_stat[0]));
        req_valid = v; req_write = w; req_addr = a; req_size = s; req_wdata = d;
        model(v, w, a, s, d);
    endtask

    task automatic wr16(logic [7:0] a, logic [15:0] d); step(1, 1, a, 1, {16'h0, d}); endtask
    task automatic wr32(logic [7:0] a, logic [31:0] d); step(1, 1, a, 2, d); endtask
    task automatic rd16(logic [7:0] a); step(1, 0, a, 1, 0); endtask
    task automatic rd32(logic [7:0] a); step(1, 0, a, 2, 0); endtask
    task automatic idle(); step(0, 0, 0, 0, 0); endtask
    task automatic read_data(); for (int k = 0; k < 4; k++) rd32(8'h80 + 8'(4*k)); endtask
    task automatic clear_data(); for (int k = 0; k < 4; k++) wr32(8'h80 + 8'(4*k), 0); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        tag = "R1";
        idle();
        rd16(8'h00); rd16(8'h04); rd16(8'h08); rd32(8'h0C); read_data();
        // R10 plain register write/readback
        tag = "R10";
        wr32(8'h0C, 32'hCAFE_0123); rd32(8'h0C);
        wr16(8'h04, 16'h5A3C); rd16(8'h04); wr16(8'h04, 16'hFFFF);
        wr32(8'h80, 32'h0302_0100); wr32(8'h84, 32'h0706_0504);
        wr32(8'h88, 32'h0B0A_0908); wr32(8'h8C, 32'h0F0E_0D0C); read_data();
        // R5 page write, R9 done + W1C
        tag = "R5";
        wr16(8'h00, 16'h8005); idle();
        tag = "R9";
        rd16(8'h08); wr16(8'h08, 16'h0000); rd16(8'h08);
        wr16(8'h08, 16'h0001); idle(); rd16(8'h08);
        // R6 page read
        tag = "R6";
        clear_data(); wr16(8'h00, 16'h2005); read_data();
        // R8 masked write then masked read
        tag = "R8";
        wr32(8'h80, 32'hAAAA_AAAA); wr32(8'h84, 32'hBBBB_BBBB);
        wr32(8'h88, 32'hCCCC_CCCC); wr32(8'h8C, 32'hDDDD_DDDD);
        wr16(8'h04, 16'h00F0); wr16(8'h00, 16'h8005);
        wr16(8'h04, 16'hFFFF); clear_data(); wr16(8'h00, 16'h2005); read_data();
        wr32(8'h80, 32'h1111_1111); wr32(8'h84, 32'h2222_2222);
        wr32(8'h88, 32'h3333_3333); wr32(8'h8C, 32'h4444_4444);
        wr16(8'h04, 16'h0F0F); wr16(8'h00, 16'h2005); read_data();
        // R7 combined write then read under partial mask
        tag = "R7";
        wr16(8'h04, 16'h00FF);
        wr32(8'h80, 32'h7654_3210); wr32(8'h84, 32'hFEDC_BA98);
        wr32(8'h88, 32'h5555_5555); wr32(8'h8C, 32'h6666_6666);
        wr16(8'h00, 16'hA007); read_data();
        wr16(8'h04, 16'hFFFF); clear_data(); wr16(8'h00, 16'h2007); read_data();
        // R11 untouched page
        tag = "R11";
        wr32(8'h80, 32'h9999_9999); wr16(8'h00, 16'h212C); read_data();
        // R4 control mask
        tag = "R4";
        wr16(8'h00, 16'hFFFF); rd16(8'h00); wr16(8'h00, 16'h0403); rd16(8'h00);
        // R2 illegal sizes
        tag = "R2";
        wr16(8'h08, 16'h0001);
        step(1, 1, 8'h80, 0, 32'hDEAD_BEEF); step(1, 0, 8'h00, 3, 0);
        step(1, 1, 8'h40, 0, 1); step(1, 1, 8'h00, 0, 32'h8000);
        rd32(8'h80); rd16(8'h08);
        // R3 wrong register width and unmapped offsets
        tag = "R3";
        wr32(8'h00, 32'h0000_A001); rd32(8'h0C); wr16(8'h80, 16'h1234);
        rd32(8'h40); wr32(8'h10, 32'h1); rd16(8'h02); wr16(8'h06, 16'h0);
        rd16(8'h00); rd16(8'h08); rd32(8'h80);
        // R12 idle gap
        tag = "R12";
        idle(); idle(); rd32(8'h0C); idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule